// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block keeps one 2-bit prediction counter per table slot. It has no address tags. The fetch stage presents a program counter on the lookup port and gets back a taken or not-taken guess in the same cycle, with no register on the read path. Once a branch resolves, the execute stage presents the branch's program counter and its real outcome on the update port. The addressed counter then moves to its next state on the following clock edge.

The slot is chosen by the program counter bits that sit just above the two byte-offset bits, which are always zero. All other address bits are ignored. Two branches whose addresses agree in those bits therefore share one counter. The counter follows a hysteresis sequence rather than a plain up/down count:
- A weak not-taken counter that sees a taken branch jumps straight to strong taken.
- A weak taken counter that sees a not-taken branch drops straight to strong not-taken.

The table depth is a power-of-two parameter.

Top module: `bht_predictor`

## Requirements
- R1: After a synchronous active-low reset, every counter holds 00 and every lookup predicts not taken.
- R2: The slot index is PC[log2(DEPTH)+1:2]. PC bits [1:0] and all bits above the index are ignored. With DEPTH=4, address 16 selects slot 0 and address 28 selects slot 3.
- R3: A counter in state 10 or 11 predicts taken (lk_taken=1). A counter in state 00 or 01 predicts not taken (lk_taken=0).
- R4: A valid taken update moves the counter 00 to 01, 01 to 11, 10 to 11, and leaves 11 at 11.
- R5: A valid not-taken update moves the counter 11 to 10, 10 to 00, 01 to 00, and leaves 00 at 00.
- R6: While upd_valid is 0, no counter changes, whatever upd_pc and upd_taken carry.
- R7: When a lookup and a valid update address the same slot in one cycle, the lookup returns the old state. The new state is seen from the next cycle on.
- R8: An update changes only the counter of the slot it indexes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counter updates happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_taken | output | 1 | Prediction for lk_pc: 1 = taken |
| upd_valid | input | 1 | Qualifies the update port |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |

## Verification
Each of the four counter states is reached in turn from a cleared slot, and each of the two outcomes is applied to it. A probe outcome then follows, so that states with the same prediction are told apart: 00 versus 01, and 10 versus 11.

Address patterns check the slot mapping:
- Addresses that differ only in the offset bits or in high bits must alias.
- Addresses 16 and 28 must land in different slots.

A long pseudo-random stream of updates is run against a reference table held in the bench. After each update, every slot is read back, which exposes any write to the wrong slot. Two directed patterns complete the set: idle cycles with junk on the update port, and a same-slot lookup and update in one cycle that separates old-state from new-state reads.

// File: rtl/bht_pkg.sv
// Package: shared counter encoding and transition rules for the branch
// history table. Assumes a 2-bit state where the upper bit is the guess.
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    // Next counter state for one resolved outcome (hysteresis sequence).
    function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
        ctr_e nxt;
        if (taken) begin
            case (cur)
                CTR_STRONG_NT: nxt = CTR_WEAK_NT;
                default:       nxt = CTR_STRONG_T;
            endcase
        end else begin
            case (cur)
                CTR_STRONG_T: nxt = CTR_WEAK_T;
                default:      nxt = CTR_STRONG_NT;
            endcase
        end
        return nxt;
    endfunction

    // Guess carried by a counter state: taken for 10 and 11.
    function automatic logic ctr_guess(input ctr_e cur);
        return (cur == CTR_WEAK_T) || (cur == CTR_STRONG_T);
    endfunction

endpackage

// File: rtl/bht_index.sv
// Module: bht_index
// Extracts the table slot number from a word-aligned program counter.
// Assumes PC_W > IDX_W + 2; the two byte-offset bits and all upper bits
// are dropped, so aliasing addresses share a slot.
module bht_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    localparam int LO = 2;
    localparam int HI = IDX_W + LO - 1;

    // Slot select: the bits just above the byte offset.
    assign idx = pc[HI:LO];

    // Bits that deliberately take no part in slot selection.
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};

endmodule

// File: rtl/bht_cell.sv
// Module: bht_cell
// One 2-bit prediction counter. Loads its next state when wr_en is high;
// otherwise holds. Resets synchronously to strong not-taken.
module bht_cell
    import bht_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       taken,
    output logic [1:0] state_o
);

    ctr_e state_q;

    // Counter register: reset, update on write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTR_STRONG_NT;
        end else if (wr_en) begin
            state_q <= ctr_next(state_q, taken);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bht_table.sv
// Module: bht_table
// Array of DEPTH counters with one write port (slot decoded here) and one
// combinational read port. A read of the slot being written returns the
// pre-edge state. Assumes DEPTH = 2**IDX_W.
module bht_table
    import bht_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_taken,
    input  logic [IDX_W-1:0]   rd_idx,
    output ctr_e               rd_state,
    output logic [2*DEPTH-1:0] tbl_flat
);

    logic [DEPTH-1:0][1:0] cell_q;
    logic [DEPTH-1:0]      wr_sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Write decode for this slot.
        assign wr_sel[g] = wr_valid && (wr_idx == IDX_W'(g));

        bht_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[g]),
            .taken   (wr_taken),
            .state_o (cell_q[g])
        );

        assign tbl_flat[2*g +: 2] = cell_q[g];
    end

    // Read mux: combinational lookup of the addressed slot.
    always_comb begin
        rd_state = ctr_e'(cell_q[rd_idx]);
    end

endmodule

// File: rtl/bht_predictor.sv
// Module: bht_predictor (top)
// Tagless direct-mapped branch history table. The lookup port answers in
// the same cycle. The update port writes on the next rising edge when
// upd_valid is high. Assumes DEPTH is a power of two, at least 2.
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int IDX_W = $clog2(DEPTH);

    initial begin
        if ((1 << IDX_W) != DEPTH || DEPTH < 2)
            $error("DEPTH must be a power of two of at least 2");
        if (PC_W <= IDX_W + 2)
            $error("PC_W too narrow for DEPTH");
    end

    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   upd_idx;
    ctr_e               lk_state;
    logic [2*DEPTH-1:0] tbl_flat;

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_index (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    bht_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .rd_idx   (lk_idx),
        .rd_state (lk_state),
        .tbl_flat (tbl_flat)
    );

    // Prediction: the guess bit of the looked-up counter.
    assign lk_taken = ctr_guess(lk_state);

endmodule

// File: rtl/bht_chk.sv
// Module: bht_chk
// Checker bound to bht_predictor. Watches the update port and the whole
// counter array to confirm the transition rules and write isolation.
module bht_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic               upd_taken,
    input logic [IDX_W-1:0]   upd_idx,
    input logic [2*DEPTH-1:0] tbl_flat
);

    logic [IDX_W-1:0]   idx_d;
    logic [1:0]         ent_d;
    logic [2*DEPTH-1:0] tbl_d;
    logic               live1, live2;
    logic [1:0]         ent_now;
    logic [DEPTH-1:0]   chg;

    // History capture: last update slot, its old state, and the whole table.
    always_ff @(posedge clk) begin
        idx_d <= upd_idx;
        ent_d <= tbl_flat[2*upd_idx +: 2];
        tbl_d <= tbl_flat;
        live1 <= rst_n;
        live2 <= live1 && rst_n;
    end

    assign ent_now = tbl_flat[2*idx_d +: 2];

    for (genvar g = 0; g < DEPTH; g++) begin : g_chg
        assign chg[g] = tbl_flat[2*g +: 2] != tbl_d[2*g +: 2];
    end

    // R4
    taken_lands_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=> ent_now[0]);

    // R4
    taken_strengthens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && tbl_flat[2*upd_idx +: 2] != 2'b00) |=> (ent_now == 2'b11));

    // R5
    not_taken_lands_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=> !ent_now[0]);

    // R5
    strong_taken_weakens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && tbl_flat[2*upd_idx +: 2] == 2'b11) |=> (ent_now == 2'b10));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live2 && !upd_valid) |=> $stable(tbl_flat));

    // R8
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live2 |-> $onehot0(chg));

    logic unused_ent_d;
    assign unused_ent_d = ^ent_d;

endmodule

bind bht_predictor bht_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bht_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .upd_idx   (upd_idx),
    .tbl_flat  (tbl_flat)
);

// File: tb/tb_bht_predictor.sv
`timescale 1ns/1ps
module tb_bht_predictor;

    localparam int PC_W  = 32;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    logic [1:0] model [DEPTH];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    bht_predictor #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int slot_of(input logic [PC_W-1:0] pc);
        return int'((pc >> 2) % DEPTH);
    endfunction

    function automatic logic [1:0] nxt(input logic [1:0] s, input logic t);
        if (t) return (s == 2'd0) ? 2'd1 : 2'd3;
        return (s == 2'd3) ? 2'd2 : 2'd0;
    endfunction

    task automatic check(input logic act, input logic exp, input string rq);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pc=%0d actual=%0b expected=%0b", rq, lk_pc, act, exp);
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string rq);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check(lk_taken, model[slot_of(pc)][1], rq);
    endtask

    task automatic look_all(input string rq);
        for (int i = 0; i < DEPTH; i++) look(PC_W'(i * 4), rq);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
        @(posedge clk);
        model[slot_of(pc)] = nxt(model[slot_of(pc)], t);
        #1;
        upd_valid = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 2'd0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: cleared table, including aliasing addresses with junk bits
        look_all("R1");
        look(32'hFFFF_FFF3, "R1");

        // R2: 16 -> slot 0, 28 -> slot 3; offsets and high bits alias
        upd(32'd16, 1'b1);
        upd(32'd16, 1'b1);
        look(32'd0, "R2");
        look(32'd17, "R2");
        look(32'h8000_0010, "R2");
        look(32'd28, "R2");
        upd(32'd28 + 32'h40, 1'b1);
        upd(32'd31, 1'b1);
        look(32'd12, "R2");
        look_all("R2");

        // R3, R4, R5: every start state with each outcome, then a probe
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 2; o++) begin
                upd(32'd4, 1'b0); upd(32'd4, 1'b0);
                if (s == 1) upd(32'd4, 1'b1);
                if (s >= 2) begin upd(32'd4, 1'b1); upd(32'd4, 1'b1); end
                if (s == 2) upd(32'd4, 1'b0);
                look(32'd4, "R3");
                upd(32'd4, o[0]);
                look(32'd4, o ? "R4" : "R5");
                upd(32'd4, !model[1][1]);
                look(32'd4, o ? "R4" : "R5");
                look_all("R8");
            end
        end

        // R6: junk on an unqualified update port for several cycles
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            upd_valid = 1'b0; upd_pc = PC_W'(k * 4); upd_taken = k[0];
        end
        look_all("R6");

        // R7: same-slot lookup and update in one cycle
        upd(32'd8, 1'b0); upd(32'd8, 1'b0); upd(32'd8, 1'b1);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'd8; upd_taken = 1'b1; lk_pc = 32'd8;
        #1;
        check(lk_taken, 1'b0, "R7");
        @(posedge clk);
        model[2] = nxt(model[2], 1'b1);
        #1 upd_valid = 1'b0;
        #1 check(lk_taken, 1'b1, "R7");

        // R8 with R4/R5: pseudo-random update stream against the model
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            upd({lfsr[15:8], 8'h00, lfsr[7:0], 8'h00} | PC_W'(lfsr[3:0]), lfsr[9]);
            look_all("R8");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule